// File: doc/BRIEF.md
# Storage Operand Address Checker

This block screens one storage operand request before any memory access is made. A request gives a 24-bit start byte address, the operand's size, and the installed storage capacity. The size is either a fixed unit of 1, 2, 4 or 8 bytes, or a variable length of 1 to 256 bytes. The block decides whether the operand is misaligned (a specification exception) or reaches past installed storage (an addressing exception). When the request is clean, the block sends out the address of every byte the operand covers. It sends one address per cycle, in ascending order. Addresses wrap from the top of the 16 MiB space back to zero.

Requests are taken over a valid/ready handshake. The block handles one request at a time. A single-cycle done pulse ends every request and carries the two exception flags. When an exception is found, no byte addresses are sent out. The operand is named by its leftmost (lowest) byte address. Installed storage is taken to be contiguous from address zero.

Top module: `operand_addr_check`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `byte_valid` and `done` are 0.
- R2: A fixed operand with size code 1 (2 bytes), 2 (4 bytes) or 3 (8 bytes) whose low 1, 2 or 3 address bits are not all zero raises `done_spec_exc` in its done pulse. No byte address is sent for that request.
- R3: Size code 0 (1 byte) and every variable-length operand never raise `done_spec_exc`, whatever the start address.
- R4: If any byte of the operand, counted with wrap modulo 2^24, sits at an address greater than or equal to `req_capacity`, the done pulse carries `done_addr_exc` and no byte address is sent. A capacity of 2^24 or more means the whole space is installed.
- R5: When the specification check fails, `done_addr_exc` is 0 in that done pulse, whatever the capacity.
- R6: A request with no exception sends exactly its length in byte addresses. The length is 2^code for fixed operands and `req_len_m1`+1 for variable ones. The addresses start at `req_addr`, rise by one on consecutive cycles, and `byte_last` marks the final one.
- R7: The byte address after 24'hFFFFFF is 24'h000000, with no exception raised when capacity is full.
- R8: The first byte address, or the done pulse of a rejected request, appears in the second cycle after the accepting clock edge. For a clean request, `done` is high in the same cycle as `byte_last`.
- R9: `req_ready` is 0 from the accepting edge until after the done pulse, and `byte_valid` is never 1 while `req_ready` is 1.
- R10: `done_spec_exc` and `done_addr_exc` are 0 in every cycle in which `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_addr | input | 24 | Leftmost byte address of the operand |
| req_variable | input | 1 | 1: variable length from `req_len_m1`; 0: fixed size from `req_size` |
| req_size | input | 2 | Fixed size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_len_m1 | input | 8 | Variable length minus one |
| req_capacity | input | 25 | Installed storage in bytes; values of 2^24 and above mean full |
| byte_valid | output | 1 | `byte_addr` holds an operand byte address |
| byte_addr | output | 24 | Current operand byte address |
| byte_last | output | 1 | Final byte address of the operand |
| done | output | 1 | One-cycle end-of-request pulse |
| done_spec_exc | output | 1 | Alignment exception (valid with `done`) |
| done_addr_exc | output | 1 | Capacity exception (valid with `done`) |

## Verification
The hardest case to reach from the ports is an operand that crosses the top of the address space. It must be checked both against full capacity, where it streams cleanly through zero, and against a capacity one below full, where its top byte must be rejected. A close second is a capacity that lands exactly on the operand's last byte or one past it. Random start addresses almost never hit either case. So the stimulus aims directed requests at 24'hFFFFF8 through 24'hFFFFFF and at capacities computed as start plus length, plus or minus one. Random requests also pick capacity from a small set of values tied to the start address, so that the boundary keeps coming up.

// File: rtl/opchk_pkg.sv
package opchk_pkg;

    localparam int OA_ADDR_W = 24;
    localparam int OA_LEN_W  = 8;
    localparam int OA_CAP_W  = OA_ADDR_W + 1;
    localparam int OA_SZ_W   = 2;

    typedef logic [OA_ADDR_W-1:0] addr_t;
    typedef logic [OA_LEN_W-1:0]  len_t;
    typedef logic [OA_CAP_W-1:0]  cap_t;

    typedef enum logic [OA_SZ_W-1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } fixsz_e;

    typedef struct packed {
        addr_t  start;
        logic   variable;
        fixsz_e fsz;
        len_t   len_m1;
        cap_t   cap;
    } opreq_t;

    typedef struct packed {
        logic spec;
        logic addr;
    } exc_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_STREAM = 2'd2,
        ST_REPORT = 2'd3
    } st_e;

    // Number of bytes minus one spanned by a request
    function automatic len_t span_m1(input opreq_t r);
        len_t n;
        if (r.variable) begin
            n = r.len_m1;
        end else begin
            case (r.fsz)
                SZ_BYTE:  n = len_t'(0);
                SZ_HALF:  n = len_t'(1);
                SZ_WORD:  n = len_t'(3);
                default:  n = len_t'(7);
            endcase
        end
        return n;
    endfunction

    // Low address bits that must be zero for a fixed unit
    function automatic addr_t align_mask(input fixsz_e s);
        addr_t m;
        case (s)
            SZ_BYTE:  m = addr_t'(0);
            SZ_HALF:  m = addr_t'(1);
            SZ_WORD:  m = addr_t'(3);
            default:  m = addr_t'(7);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/opchk_rules.sv
module opchk_rules
    import opchk_pkg::*;
(
    input  opreq_t req,
    output exc_t   exc
);
    cap_t last_wide;
    logic crosses_top;
    logic cap_full;
    logic beyond;
    logic misaligned;

    always_comb begin
        misaligned  = !req.variable && ((req.start & align_mask(req.fsz)) != addr_t'(0));
        last_wide   = cap_t'(req.start) + cap_t'(span_m1(req));
        crosses_top = last_wide[OA_CAP_W-1];
        cap_full    = req.cap[OA_CAP_W-1];
        if (cap_full) begin
            beyond = 1'b0;
        end else if (crosses_top) begin
            beyond = 1'b1;
        end else begin
            beyond = (last_wide >= req.cap);
        end
        exc.spec = misaligned;
        exc.addr = beyond && !misaligned;
    end
endmodule

// File: rtl/opchk_seq.sv
module opchk_seq
    import opchk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t load_start,
    input  len_t  load_cnt_m1,
    output logic  out_valid,
    output addr_t out_addr,
    output logic  out_last
);
    logic  active;
    addr_t cur;
    len_t  left;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cur    <= '0;
            left   <= '0;
        end else if (load) begin
            active <= 1'b1;
            cur    <= load_start;
            left   <= load_cnt_m1;
        end else if (active) begin
            cur <= cur + addr_t'(1);
            if (left == len_t'(0)) begin
                active <= 1'b0;
            end else begin
                left <= left - len_t'(1);
            end
        end
    end

    assign out_valid = active;
    assign out_addr  = cur;
    assign out_last  = active && (left == len_t'(0));

    // R7
    top_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !$past(out_last) && ($past(out_addr) == {OA_ADDR_W{1'b1}}))
        |-> (out_addr == addr_t'(0)));

    // R6
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(out_valid) && !$past(out_last)) |-> out_valid);
endmodule

// File: rtl/operand_addr_check.sv
module operand_addr_check
    import opchk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [23:0] req_addr,
    input  logic        req_variable,
    input  logic [1:0]  req_size,
    input  logic [7:0]  req_len_m1,
    input  logic [24:0] req_capacity,
    output logic        byte_valid,
    output logic [23:0] byte_addr,
    output logic        byte_last,
    output logic        done,
    output logic        done_spec_exc,
    output logic        done_addr_exc
);
    st_e    st;
    opreq_t req_q;
    exc_t   exc_now;
    exc_t   exc_q;
    logic   seq_load;
    logic   seq_valid;
    addr_t  seq_addr;
    logic   seq_last;

    opchk_rules u_rules (
        .req (req_q),
        .exc (exc_now)
    );

    assign seq_load = (st == ST_CHECK) && !(exc_now.spec || exc_now.addr);

    opchk_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .load        (seq_load),
        .load_start  (req_q.start),
        .load_cnt_m1 (span_m1(req_q)),
        .out_valid   (seq_valid),
        .out_addr    (seq_addr),
        .out_last    (seq_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            req_q <= '0;
            exc_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q.start    <= req_addr;
                        req_q.variable <= req_variable;
                        req_q.fsz      <= fixsz_e'(req_size);
                        req_q.len_m1   <= req_len_m1;
                        req_q.cap      <= req_capacity;
                        st             <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (exc_now.spec || exc_now.addr) begin
                        exc_q <= exc_now;
                        st    <= ST_REPORT;
                    end else begin
                        st <= ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (seq_last) st <= ST_IDLE;
                end
                default: begin
                    exc_q <= '0;
                    st    <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready     = (st == ST_IDLE);
    assign byte_valid    = seq_valid;
    assign byte_addr     = seq_addr;
    assign byte_last     = seq_last;
    assign done          = (st == ST_REPORT) || seq_last;
    assign done_spec_exc = (st == ST_REPORT) && exc_q.spec;
    assign done_addr_exc = (st == ST_REPORT) && exc_q.addr;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (req_ready && !byte_valid && !done));

    // R5
    exc_priority_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_spec_exc && done_addr_exc));

    // R2
    no_bytes_on_exc_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (done_spec_exc || done_addr_exc)) |-> !byte_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !byte_valid);

    // R10
    flags_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!done_spec_exc && !done_addr_exc));

    // R8
    check_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!byte_valid && !done && !req_ready));
endmodule

// File: tb/operand_addr_check_bench.sv
module operand_addr_check_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_variable = 1'b0;
    logic [1:0]  req_size = '0;
    logic [7:0]  req_len_m1 = '0;
    logic [24:0] req_capacity = '0;
    logic        byte_valid;
    logic [23:0] byte_addr;
    logic        byte_last;
    logic        done;
    logic        done_spec_exc;
    logic        done_addr_exc;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    localparam logic [24:0] FULL = 25'h1000000;

    always #2.5 clk = ~clk;

    operand_addr_check u_operand_addr_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_variable(req_variable), .req_size(req_size),
        .req_len_m1(req_len_m1), .req_capacity(req_capacity),
        .byte_valid(byte_valid), .byte_addr(byte_addr), .byte_last(byte_last),
        .done(done), .done_spec_exc(done_spec_exc), .done_addr_exc(done_addr_exc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input bit v, input logic [1:0] c, input logic [7:0] lm);
        return v ? int'(lm) + 1 : (1 << c);
    endfunction

    function automatic bit exp_spec(input logic [23:0] a, input bit v, input logic [1:0] c);
        int m;
        m = (1 << c) - 1;
        return !v && ((int'(a) & m) != 0);
    endfunction

    function automatic bit exp_addr(input logic [23:0] a, input int n, input logic [24:0] cap);
        bit hit = 1'b0;
        for (int i = 0; i < n; i++) begin
            longint unsigned b;
            b = (longint'(a) + longint'(i)) % 64'd16777216;
            if (b >= longint'(cap)) hit = 1'b1;
        end
        return hit;
    endfunction

    task automatic run_op(input logic [23:0] a, input bit v, input logic [1:0] c,
                          input logic [7:0] lm, input logic [24:0] cap);
        int  n;
        bit  es;
        bit  ea;
        int  nb = 0;
        int  bad_addr = 0;
        longint first_bad_act = 0;
        longint first_bad_exp = 0;
        int  k = 1;
        int  first_k = 0;
        bit  got_done = 1'b0;
        bit  got_spec = 1'b0;
        bit  got_addr = 1'b0;
        bit  last_ok = 1'b1;
        bit  busy_ok = 1'b1;
        bit  gate_ok = 1'b1;
        n  = exp_len(v, c, lm);
        es = exp_spec(a, v, c);
        ea = !es && exp_addr(a, n, cap);
        @(negedge clk);
        chk(req_ready === 1'b1, "R9", "ready before request", longint'(req_ready), 1);
        req_addr = a; req_variable = v; req_size = c; req_len_m1 = lm;
        req_capacity = cap; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (byte_valid || done || req_ready) busy_ok = 1'b0;
        while (!got_done && k < 600) begin
            @(negedge clk);
            k++;
            if (req_ready && !done) busy_ok = 1'b0;
            if (!done && (done_spec_exc || done_addr_exc)) gate_ok = 1'b0;
            if ((byte_valid || done) && first_k == 0) first_k = k;
            if (byte_valid) begin
                longint e;
                e = (longint'(a) + longint'(nb)) % 64'd16777216;
                if (longint'(byte_addr) != e) begin
                    if (bad_addr == 0) begin
                        first_bad_act = longint'(byte_addr);
                        first_bad_exp = e;
                    end
                    bad_addr++;
                end
                nb++;
                if (byte_last != done) last_ok = 1'b0;
            end
            if (done) begin
                got_done = 1'b1;
                got_spec = done_spec_exc;
                got_addr = done_addr_exc;
            end
        end
        chk(got_done, "R8", "done pulse seen", longint'(got_done), 1);
        chk(got_spec == es, (v || c == 2'd0) ? "R3" : "R2", "spec flag", longint'(got_spec), longint'(es));
        chk(got_addr == ea, es ? "R5" : "R4", "addr flag", longint'(got_addr), longint'(ea));
        chk(nb == ((es || ea) ? 0 : n), "R6", "byte count", nb, (es || ea) ? 0 : n);
        chk(bad_addr == 0, "R7", "byte address sequence", first_bad_act, first_bad_exp);
        chk(first_k == 2, "R8", "first output cycle", first_k, 2);
        chk(last_ok, "R8", "done with byte_last", longint'(last_ok), 1);
        chk(busy_ok, "R9", "ready low while busy", longint'(busy_ok), 1);
        chk(gate_ok, "R10", "flags low outside done", longint'(gate_ok), 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_0360;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1 && byte_valid === 1'b0 && done === 1'b0, "R1",
            "reset outputs", {req_ready, byte_valid, done}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1 && byte_valid === 1'b0 && done === 1'b0, "R1",
            "after reset", {req_ready, byte_valid, done}, 3'b100);

        // directed corner cases
        run_op(24'h000101, 1'b0, 2'd0, 8'd0, FULL);          // R3 single byte odd
        run_op(24'h000102, 1'b0, 2'd1, 8'd0, FULL);          // aligned half
        run_op(24'h000102, 1'b0, 2'd2, 8'd0, FULL);          // R2 word misaligned
        run_op(24'h000104, 1'b0, 2'd3, 8'd0, FULL);          // R2 dword misaligned
        run_op(24'h000108, 1'b0, 2'd3, 8'd0, FULL);          // aligned dword
        run_op(24'h000333, 1'b1, 2'd3, 8'd9, FULL);          // R3 variable odd start
        run_op(24'hFFFFFE, 1'b1, 2'd0, 8'd3, FULL);          // R7 wrap clean
        run_op(24'hFFFFF8, 1'b0, 2'd3, 8'd0, FULL);          // top dword
        run_op(24'hFFFFFC, 1'b1, 2'd0, 8'd7, 25'hFFFFFF);    // R4 wrap beyond
        run_op(24'h001000, 1'b1, 2'd0, 8'd15, 25'h001010);   // R4 exactly fits
        run_op(24'h001000, 1'b1, 2'd0, 8'd15, 25'h00100F);   // R4 one byte over
        run_op(24'h000003, 1'b0, 2'd2, 8'd0, 25'h0);         // R5 both fail
        run_op(24'h000000, 1'b0, 2'd0, 8'd0, 25'h0);         // R4 capacity zero
        run_op(24'h000010, 1'b1, 2'd0, 8'd255, FULL);        // longest operand
        run_op(24'hFFFF80, 1'b1, 2'd0, 8'd255, 25'h1FFFFFF); // wrap, large cap

        // random requests
        for (int t = 0; t < 300; t++) begin
            logic [23:0] a;
            bit          v;
            logic [1:0]  c;
            logic [7:0]  lm;
            logic [24:0] cap;
            int          n;
            int unsigned pick;
            a  = 24'($urandom());
            v  = 1'($urandom());
            c  = 2'($urandom());
            lm = 8'($urandom_range(0, 40));
            if (!v && $urandom_range(0, 1) == 1) a = a & ~24'((1 << c) - 1);
            if ($urandom_range(0, 5) == 0) a = 24'hFFFFFF - 24'($urandom_range(0, 20));
            n = exp_len(v, c, lm);
            pick = $urandom_range(0, 4);
            case (pick)
                0: cap = FULL;
                1: cap = 25'($urandom_range(0, 32'h1000000));
                2: cap = 25'(a) + 25'(n);
                3: cap = 25'(a) + 25'(n) - 25'd1;
                default: cap = 25'hFFFFFF;
            endcase
            run_op(a, v, c, lm, cap);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule